// File: doc/BRIEF.md
# Eight-Way Bus Arbiter with Idle Parking

This block decides which of eight bus masters owns a shared bus. Each master raises its bit of a request vector. The arbiter answers with a registered grant vector that is either one-hot or all zero. While the current owner signals that a transfer is in progress, the grant is frozen. When the owner is idle, the next owner is chosen round-robin, starting after the master that was granted most recently.

A 32-bit configuration word is written through a single-cycle write strobe and can be read back at any time. It decides what happens to the bus when no master is requesting. The bus can be left unowned, left with the most recent owner, or handed to a master named in a field of the word.

A pipeline-off bit forces a dead cycle between two different owners. Clearing it allows the new grant in the same cycle the old owner goes idle. Three timeout-enable bits are storage only; no timeout logic exists behind them.

Top module: `bus_park_arbiter`

## Requirements
- R1: The grant output is always one-hot or all zero. Bit i of the grant belongs to master i (0 to 7). A master with an active request is granted only through arbitration.
- R2: With the owner idle and requests pending, the next grant goes to the first requesting master found counting upward, with wrap, from the master after the most recently granted one. After reset that search starts at master 0.
- R3: While the grant is non-zero and `busy` is high, the grant does not change, whatever the requests do.
- R4: Park mode field `cfg[2:1]` = 00 is the reset value. In this mode, with no request and an idle owner, the grant returns to zero one cycle later.
- R5: Park mode 01 behaves exactly as mode 00.
- R6: In park mode 10, with no request, the most recently granted master keeps its grant. If that master requests again, it keeps the bus with no gap.
- R7: In park mode 11, with no request, the grant goes to the master whose number is held in the select field `cfg[6:4]` (value k means master k). A parked master that requests keeps the bus.
- R8: The pipeline-off bit `cfg[0]` resets to 1. While it is 1, a change from one owner to a different owner passes through one cycle of all-zero grant. While it is 0, the new owner is granted in the cycle right after the old owner goes idle.
- R9: The timeout-enable bits `cfg[10:8]` (address, data, whole-bus) are written and read back, and have no effect on the grant.
- R10: A write stores the word on the clock edge where `cfg_we` is high, and `cfg_rdata` shows it from then on. Every other bit reads as zero. The word read right after reset is 0x0000_0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 8 | Per-master bus request |
| busy | input | 1 | Current owner is mid-transfer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| gnt | output | 8 | One-hot bus grant, zero when unowned |

## Verification
The assertions assume that `busy` is only meaningful while a grant is out. They also assume it is driven by the owner, so a high `busy` with no grant carries no meaning. The parking and dead-cycle properties look at the configuration as it stood before the edge that updates the grant, which is the same value the logic uses. The stimulus follows these assumptions. Inputs change only on the falling edge. `busy` is raised only while a grant is held. Configuration writes happen while requests are low, so each mode is exercised one step at a time from a known owner.

// File: rtl/arb_pkg.sv
// Package: shared constants and types for the parking bus arbiter.
// Assumes a 32-bit configuration word with the field positions below.
package arb_pkg;
    parameter int N_MST   = 8;
    parameter int CFG_W   = 32;
    parameter int SEL_W   = 3;
    parameter int TO_W    = 3;

    localparam int POS_PIPE = 0;
    localparam int POS_MODE = 1;
    localparam int POS_SEL  = 4;
    localparam int POS_TO   = 8;

    typedef enum logic [1:0] {
        PARK_NONE = 2'b00,
        PARK_RSVD = 2'b01,
        PARK_LAST = 2'b10,
        PARK_SEL  = 2'b11
    } park_mode_e;

    typedef struct packed {
        logic             pipe_off;
        park_mode_e       mode;
        logic [SEL_W-1:0] sel;
    } arb_ctl_t;
endpackage

// File: rtl/arb_cfg_regs.sv
// Module: configuration word storage.
// Holds the arbiter control word; reserved bits are forced to zero on write.
// Assumes writes are single-cycle strobes; read data is the stored word.
module arb_cfg_regs
    import arb_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output arb_ctl_t     ctl
);
    localparam logic [W-1:0] PIPE_M = W'(1) << POS_PIPE;
    localparam logic [W-1:0] MODE_M = W'(3) << POS_MODE;
    localparam logic [W-1:0] SEL_M  = W'((1 << SEL_W) - 1) << POS_SEL;
    localparam logic [W-1:0] TO_M   = W'((1 << TO_W) - 1) << POS_TO;
    localparam logic [W-1:0] MASK   = PIPE_M | MODE_M | SEL_M | TO_M;
    localparam logic [W-1:0] RST_V  = PIPE_M;

    logic [W-1:0] word_q;

    // Store the masked word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= RST_V;
        else if (we)
            word_q <= wdata & MASK;
    end

    // Decode the fields the grant logic uses.
    always_comb begin
        rdata        = word_q;
        ctl.pipe_off = word_q[POS_PIPE];
        ctl.mode     = park_mode_e'(word_q[POS_MODE +: 2]);
        ctl.sel      = word_q[POS_SEL +: SEL_W];
    end
endmodule

// File: rtl/arb_rr_pick.sv
// Module: round-robin picker.
// Finds the first active request after the last granted index, with wrap.
// Purely combinational; assumes last_idx < N.
module arb_rr_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last_idx,
    output logic [N-1:0]     pick_oh,
    output logic             any
);
    localparam logic [N-1:0] ONE = N'(1);
    logic [IDX_W-1:0] pick_idx;

    // Scan from last_idx+1 around the ring and take the first hit.
    always_comb begin
        any      = 1'b0;
        pick_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last_idx) + k) % N;
            if (!any && req[c]) begin
                any      = 1'b1;
                pick_idx = IDX_W'(c);
            end
        end
        pick_oh = any ? (ONE << pick_idx) : '0;
    end
endmodule

// File: rtl/arb_grant_ctrl.sv
// Module: grant state machine.
// Holds the grant while the owner is busy. Otherwise it takes the round-robin
// pick or the parking target, and inserts a dead cycle when pipelining is off.
// Assumes busy is only meaningful while a grant is out.
module arb_grant_ctrl
    import arb_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  arb_ctl_t         ctl,
    input  logic [N-1:0]     pick_oh,
    input  logic             any,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] last_idx
);
    localparam logic [N-1:0] ONE = N'(1);

    logic [N-1:0]     gnt_q, gnt_d, park_oh, cand;
    logic [IDX_W-1:0] last_q, last_d;
    logic             seen_q, hold;

    // Work out the parking target for an idle bus.
    always_comb begin
        case (ctl.mode)
            PARK_LAST: park_oh = seen_q ? (ONE << last_q) : '0;
            PARK_SEL:  park_oh = (int'(ctl.sel) < N) ? (ONE << ctl.sel) : '0;
            default:   park_oh = '0;
        endcase
    end

    // Choose the next grant: hold, dead cycle, or candidate.
    always_comb begin
        hold = (gnt_q != '0) && busy;
        cand = any ? pick_oh : park_oh;
        if (hold)
            gnt_d = gnt_q;
        else if (ctl.pipe_off && gnt_q != '0 && cand != '0 && cand != gnt_q)
            gnt_d = '0;
        else
            gnt_d = cand;
    end

    // Encode the index of the next owner for the round-robin pointer.
    always_comb begin
        last_d = last_q;
        for (int i = 0; i < N; i++)
            if (gnt_d[i]) last_d = IDX_W'(i);
    end

    // Register grant, last owner and the has-owned flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            last_q <= IDX_W'(N - 1);
            seen_q <= 1'b0;
        end else begin
            gnt_q  <= gnt_d;
            last_q <= last_d;
            if (gnt_d != '0) seen_q <= 1'b1;
        end
    end

    assign gnt      = gnt_q;
    assign last_idx = last_q;
endmodule

// File: rtl/bus_park_arbiter.sv
// Module: top of the parking bus arbiter.
// Wires the configuration storage, the round-robin picker and the grant control.
// Assumes one clock domain and a synchronous active-low reset.
module bus_park_arbiter
    import arb_pkg::*;
#(
    parameter int N_MST = arb_pkg::N_MST,
    parameter int W     = arb_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    input  logic             busy,
    input  logic             cfg_we,
    input  logic [W-1:0]     cfg_wdata,
    output logic [W-1:0]     cfg_rdata,
    output logic [N_MST-1:0] gnt
);
    localparam int IDX_W = $clog2(N_MST);

    arb_ctl_t         ctl;
    logic [N_MST-1:0] pick_oh;
    logic             any;
    logic [IDX_W-1:0] last_idx;

    arb_cfg_regs #(.W(W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .ctl(ctl)
    );

    arb_rr_pick #(.N(N_MST), .IDX_W(IDX_W)) u_pick (
        .req(req), .last_idx(last_idx), .pick_oh(pick_oh), .any(any)
    );

    arb_grant_ctrl #(.N(N_MST), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .busy(busy), .ctl(ctl),
        .pick_oh(pick_oh), .any(any), .gnt(gnt), .last_idx(last_idx)
    );
endmodule

// File: rtl/bus_park_arbiter_chk.sv
// Module: property checker for the parking bus arbiter, bound to the top.
// Assumes busy is only meaningful while a grant is held.
module bus_park_arbiter_chk #(
    parameter int N_MST = 8,
    parameter int W     = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MST-1:0] req,
    input logic             busy,
    input logic [W-1:0]     cfg_rdata,
    input logic [N_MST-1:0] gnt
);
    localparam logic [W-1:0] LEGAL = W'(32'h0000_0777);
    localparam logic [N_MST-1:0] ONE = N_MST'(1);

    logic owner_busy;
    assign owner_busy = (gnt != '0) && busy;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R1

    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        owner_busy |=> $stable(gnt)); // R3

    AST_NO_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[2] && req == '0 && !owner_busy) |=> gnt == '0); // R4

    AST_PARK_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2:1] == 2'b11 && !cfg_rdata[0] && req == '0 && !owner_busy)
        |=> gnt == (ONE << $past(cfg_rdata[6:4]))); // R7

    AST_DEAD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[0] && gnt != '0 && !busy)
        |=> (gnt == '0 || gnt == $past(gnt))); // R8

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~LEGAL) == '0); // R10
endmodule

bind bus_park_arbiter bus_park_arbiter_chk #(.N_MST(N_MST), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(busy),
    .cfg_rdata(cfg_rdata), .gnt(gnt)
);

// File: tb/bus_park_arbiter_tb_top.sv
// Bench: directed scenarios for the parking bus arbiter, one task each.
module bus_park_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req = '0;
    logic        busy = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  gnt;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bus_park_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .busy(busy),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gnt(gnt)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_gnt(input string tag, input logic [7:0] exp);
        n_chk++;
        if (gnt !== exp) begin
            n_bad++;
            $display("FAIL %s gnt actual=%h expected=%h", tag, gnt, exp);
        end
    endtask

    task automatic chk_cfg(input string tag, input logic [31:0] exp);
        n_chk++;
        if (cfg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s cfg actual=%h expected=%h", tag, cfg_rdata, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        chk_gnt("R4 reset", 8'h00);
        chk_cfg("R10 reset", 32'h1);
        chk_cfg("R8 reset pipe off", 32'h1);
    endtask

    task automatic t_cfg_rsvd();
        wr(32'hFFFF_FFFF);
        chk_cfg("R10 rsvd mask", 32'h777);
        chk_cfg("R9 enables set", 32'h777);
        tick();
        chk_gnt("R7 park sel7", 8'h80);
        wr(32'h0);
        tick();
        chk_gnt("R4 no park", 8'h00);
    endtask

    task automatic t_round_robin();
        req = 8'h25;
        tick(); chk_gnt("R2 rr 0", 8'h01);
        tick(); chk_gnt("R2 rr 2", 8'h04);
        tick(); chk_gnt("R2 rr 5", 8'h20);
        tick(); chk_gnt("R2 rr wrap", 8'h01);
        req = 8'h00;
        tick(); chk_gnt("R4 release", 8'h00);
    endtask

    task automatic t_busy_hold();
        req = 8'h02;
        tick(); chk_gnt("R1 single", 8'h02);
        busy = 1'b1; req = 8'h0A;
        for (int i = 0; i < 3; i++) begin
            tick(); chk_gnt("R3 hold", 8'h02);
        end
        busy = 1'b0; req = 8'h08;
        tick(); chk_gnt("R8 pipelined switch", 8'h08);
        req = 8'h00;
        tick(); chk_gnt("R4 idle", 8'h00);
    endtask

    task automatic t_pipe_off();
        wr(32'h1);
        req = 8'h10;
        tick(); chk_gnt("R8 first owner", 8'h10);
        req = 8'h40;
        tick(); chk_gnt("R8 dead cycle", 8'h00);
        tick(); chk_gnt("R8 new owner", 8'h40);
        req = 8'h00;
        tick(); chk_gnt("R4 idle", 8'h00);
    endtask

    task automatic t_park_last();
        wr(32'h4);
        req = 8'h02;
        tick(); chk_gnt("R6 grant", 8'h02);
        req = 8'h00;
        for (int i = 0; i < 3; i++) begin
            tick(); chk_gnt("R6 parked", 8'h02);
        end
        req = 8'h02;
        tick(); chk_gnt("R6 rerequest", 8'h02);
        req = 8'h00;
    endtask

    task automatic t_park_sel();
        wr(32'h57);
        chk_cfg("R10 readback", 32'h57);
        chk_gnt("R6 before mode takes", 8'h02);
        tick(); chk_gnt("R8 gap to park", 8'h00);
        tick(); chk_gnt("R7 park sel5", 8'h20);
        req = 8'h20;
        tick(); chk_gnt("R7 parked keeps", 8'h20);
        req = 8'h00;
    endtask

    task automatic t_mode01();
        wr(32'h2);
        chk_cfg("R5 readback", 32'h2);
        tick(); chk_gnt("R5 drops park", 8'h00);
        req = 8'h01;
        tick(); chk_gnt("R5 grant", 8'h01);
        req = 8'h00;
        tick(); chk_gnt("R5 no park", 8'h00);
    endtask

    task automatic t_timeouts();
        wr(32'h700);
        chk_cfg("R9 enables", 32'h700);
        tick(); chk_gnt("R9 no effect", 8'h00);
        wr(32'hFFFF_F888);
        chk_cfg("R10 rsvd only", 32'h0);
        tick(); chk_gnt("R4 after clear", 8'h00);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_cfg_rsvd();
        t_round_robin();
        t_busy_hold();
        t_pipe_off();
        t_park_last();
        t_park_sel();
        t_mode01();
        t_timeouts();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule